// File: doc/BRIEF.md
# SIMD Integer Compare Unit

This unit takes one 32-bit compare instruction and two 128-bit source vectors. It decodes the lane size and the relation from the instruction, then compares the vectors lane by lane. Lanes are 8, 16 or 32 bits wide. Each destination lane of the mask becomes all ones where the relation holds and all zeros where it fails. The supported relations are equality, unsigned greater-than and signed greater-than.

When the instruction's record bit is set, the unit also produces a 4-bit condition summary for the whole vector, which tells whether the relation held in every lane or in none, together with a write enable for that summary. An instruction word that is not one of the recognised compares raises an illegal flag. Such a word yields no mask bits and no summary write.

Every result is registered and appears one cycle after the input strobe. The unit does not read the register file and does not store condition fields; the surrounding pipeline handles both.

Top module: `simd_cmp_unit`

## Requirements
- R1: Instruction bit 0 is the word's most significant bit, so bits 0-5 are `insn[31:26]` and must hold 4. The record bit (bit 21) is `insn[10]`, and the extended opcode (bits 22-31) is `insn[9:0]`. Bits 6-20 (`insn[25:11]`) have no effect on the result.
- R2: Vector bit 0 is the most significant bit, and lane i of width w covers vector bits i*w to i*w+w-1. Extended opcode 6 compares 16 byte lanes for equality. Each mask lane is all ones when its lanes are equal and all zeros when they are not.
- R3: Extended opcode 70 compares 8 halfword lanes for equality, and each mask lane is filled uniformly.
- R4: Extended opcode 134 compares 4 word lanes for equality, and each mask lane is filled uniformly.
- R5: Extended opcodes 518, 582 and 646 test A > B on byte, halfword and word lanes respectively. These compares treat the lanes as unsigned magnitudes.
- R6: Extended opcodes 774, 838 and 902 test A > B on byte, halfword and word lanes respectively. These compares treat the lanes as two's complement values.
- R7: When the record bit is 1 and the instruction is legal, `cond_we` is 1. In that case `cond[3]` is 1 exactly when every mask bit is 1, `cond[1]` is 1 exactly when every mask bit is 0, and `cond[2]` and `cond[0]` are 0.
- R8: When the record bit is 0, `cond_we` is 0 and `cond` reads 0.
- R9: Any instruction word with a wrong primary opcode or an unlisted extended opcode sets `illegal` to 1, makes `mask` read zero, keeps `cond_we` at 0 and makes `cond` read 0.
- R10: `out_valid`, `mask`, `cond`, `cond_we` and `illegal` update one cycle after `in_valid`. In a cycle without `in_valid`, `out_valid`, `cond_we`, `cond` and `illegal` read 0, and `mask` holds its previous value.
- R11: A synchronous active-high `rst` clears every output to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Instruction and operands are present this cycle |
| insn | input | 32 | Compare instruction word |
| src_a | input | 128 | First source vector |
| src_b | input | 128 | Second source vector |
| out_valid | output | 1 | Registered results are valid |
| mask | output | 128 | Per-lane result mask |
| cond | output | 4 | Condition summary {all-true, 0, all-false, 0} |
| cond_we | output | 1 | Summary write enable |
| illegal | output | 1 | Instruction was not a recognised compare |

## Verification
The bench builds the unit with its default 128-bit vector width, which gives all three lane sizes: 16, 8 and 4 lanes. With these lane counts, a single crafted operand pair can mix true and false lanes, make every lane true, or make every lane false. Operand values near the sign boundary, such as 0x80 against 0x7F, make unsigned and signed greater-than disagree. Back-to-back instructions and idle gaps exercise the one-cycle latency and the hold behaviour of the mask.

// File: rtl/simd_cmp_pkg.sv
package simd_cmp_pkg;

    localparam int INSN_W = 32;
    localparam logic [5:0] PRIMARY_OP = 6'd4;

    localparam logic [9:0] XO_EQ_B  = 10'd6;
    localparam logic [9:0] XO_EQ_H  = 10'd70;
    localparam logic [9:0] XO_EQ_W  = 10'd134;
    localparam logic [9:0] XO_GTU_B = 10'd518;
    localparam logic [9:0] XO_GTU_H = 10'd582;
    localparam logic [9:0] XO_GTU_W = 10'd646;
    localparam logic [9:0] XO_GTS_B = 10'd774;
    localparam logic [9:0] XO_GTS_H = 10'd838;
    localparam logic [9:0] XO_GTS_W = 10'd902;

    typedef enum logic [1:0] {
        LS_BYTE = 2'd0,
        LS_HALF = 2'd1,
        LS_WORD = 2'd2
    } lane_sz_e;

    typedef enum logic [1:0] {
        REL_EQ  = 2'd0,
        REL_GTU = 2'd1,
        REL_GTS = 2'd2
    } rel_e;

    typedef struct packed {
        logic     legal;
        logic     rec;
        lane_sz_e sz;
        rel_e     rel;
    } cmp_op_t;

    function automatic cmp_op_t decode_insn(input logic [5:0] prim,
                                            input logic       rc,
                                            input logic [9:0] xo);
        cmp_op_t op;
        op.legal = (prim == PRIMARY_OP);
        op.rec   = rc;
        op.sz    = LS_BYTE;
        op.rel   = REL_EQ;
        case (xo)
            XO_EQ_B:  begin op.sz = LS_BYTE; op.rel = REL_EQ;  end
            XO_EQ_H:  begin op.sz = LS_HALF; op.rel = REL_EQ;  end
            XO_EQ_W:  begin op.sz = LS_WORD; op.rel = REL_EQ;  end
            XO_GTU_B: begin op.sz = LS_BYTE; op.rel = REL_GTU; end
            XO_GTU_H: begin op.sz = LS_HALF; op.rel = REL_GTU; end
            XO_GTU_W: begin op.sz = LS_WORD; op.rel = REL_GTU; end
            XO_GTS_B: begin op.sz = LS_BYTE; op.rel = REL_GTS; end
            XO_GTS_H: begin op.sz = LS_HALF; op.rel = REL_GTS; end
            XO_GTS_W: begin op.sz = LS_WORD; op.rel = REL_GTS; end
            default:  op.legal = 1'b0;
        endcase
        return op;
    endfunction

endpackage

// File: rtl/simd_cmp_decode.sv
module simd_cmp_decode
    import simd_cmp_pkg::*;
(
    input  logic [INSN_W-1:0] insn,
    output cmp_op_t           op
);
    // Register-number fields (insn bits 6-20) do not affect the compare.
    logic unused_reg_fields;
    assign unused_reg_fields = ^insn[25:11];

    always_comb begin
        op = decode_insn(insn[31:26], insn[10], insn[9:0]);
    end
endmodule

// File: rtl/simd_cmp_lanes.sv
module simd_cmp_lanes
    import simd_cmp_pkg::*;
#(
    parameter int VEC_W  = 128,
    parameter int LANE_W = 8
) (
    input  logic [VEC_W-1:0] va,
    input  logic [VEC_W-1:0] vb,
    input  rel_e             rel,
    output logic [VEC_W-1:0] lane_mask
);
    localparam int N_LANES = VEC_W / LANE_W;

    for (genvar i = 0; i < N_LANES; i++) begin : g_lane
        localparam int TOP = VEC_W - 1 - i * LANE_W;
        logic [LANE_W-1:0] la, lb;
        logic hit;
        assign la = va[TOP -: LANE_W];
        assign lb = vb[TOP -: LANE_W];
        always_comb begin
            case (rel)
                REL_GTU: hit = (la > lb);
                REL_GTS: hit = ($signed(la) > $signed(lb));
                default: hit = (la == lb);
            endcase
        end
        assign lane_mask[TOP -: LANE_W] = {LANE_W{hit}};
    end
endmodule

// File: rtl/simd_cmp_summary.sv
module simd_cmp_summary
    import simd_cmp_pkg::*;
#(
    parameter int VEC_W = 128
) (
    input  logic [VEC_W-1:0] res,
    input  cmp_op_t          op,
    output logic [3:0]       cond_nxt,
    output logic             we_nxt
);
    logic all_true, all_false;
    assign all_true  = &res;
    assign all_false = ~|res;

    always_comb begin
        we_nxt   = op.legal & op.rec;
        cond_nxt = we_nxt ? {all_true, 1'b0, all_false, 1'b0} : 4'b0000;
    end
endmodule

// File: rtl/simd_cmp_unit.sv
module simd_cmp_unit
    import simd_cmp_pkg::*;
#(
    parameter int VEC_W = 128
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              in_valid,
    input  logic [INSN_W-1:0] insn,
    input  logic [VEC_W-1:0]  src_a,
    input  logic [VEC_W-1:0]  src_b,
    output logic              out_valid,
    output logic [VEC_W-1:0]  mask,
    output logic [3:0]        cond,
    output logic              cond_we,
    output logic              illegal
);
    localparam int N_SZ = 3;

    cmp_op_t op;
    logic [VEC_W-1:0] mask_by_sz [N_SZ];
    logic [VEC_W-1:0] sel_mask;
    logic [3:0]       cond_nxt;
    logic             we_nxt;

    simd_cmp_decode u_dec (
        .insn (insn),
        .op   (op)
    );

    for (genvar g = 0; g < N_SZ; g++) begin : g_sz
        simd_cmp_lanes #(
            .VEC_W  (VEC_W),
            .LANE_W (8 << g)
        ) u_lanes (
            .va        (src_a),
            .vb        (src_b),
            .rel       (op.rel),
            .lane_mask (mask_by_sz[g])
        );
    end

    always_comb begin
        sel_mask = '0;
        if (op.legal) begin
            case (op.sz)
                LS_HALF: sel_mask = mask_by_sz[1];
                LS_WORD: sel_mask = mask_by_sz[2];
                default: sel_mask = mask_by_sz[0];
            endcase
        end
    end

    simd_cmp_summary #(
        .VEC_W (VEC_W)
    ) u_sum (
        .res      (sel_mask),
        .op       (op),
        .cond_nxt (cond_nxt),
        .we_nxt   (we_nxt)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid <= 1'b0;
            mask      <= '0;
            cond      <= '0;
            cond_we   <= 1'b0;
            illegal   <= 1'b0;
        end else begin
            out_valid <= in_valid;
            if (in_valid) begin
                mask    <= sel_mask;
                cond    <= cond_nxt;
                cond_we <= we_nxt;
                illegal <= ~op.legal;
            end else begin
                cond    <= '0;
                cond_we <= 1'b0;
                illegal <= 1'b0;
            end
        end
    end
endmodule

// File: rtl/simd_cmp_unit_chk.sv
module simd_cmp_unit_chk #(
    parameter int VEC_W = 128
) (
    input logic             clk,
    input logic             rst,
    input logic             in_valid,
    input logic             out_valid,
    input logic [VEC_W-1:0] mask,
    input logic [3:0]       cond,
    input logic             cond_we,
    input logic             illegal
);
    // R10
    valid_latency_chk: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> out_valid);

    // R10
    idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> (!out_valid && $stable(mask) && !cond_we && !illegal));

    // R7
    summary_fields_chk: assert property (@(posedge clk) disable iff (rst)
        cond_we |-> (out_valid && cond[3] == (&mask) && cond[1] == (~|mask)
                     && !cond[2] && !cond[0]));

    // R8
    summary_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        !cond_we |-> (cond == 4'b0000));

    // R9
    illegal_kill_chk: assert property (@(posedge clk) disable iff (rst)
        illegal |-> (out_valid && mask == '0 && !cond_we));

    // R2
    for (genvar k = 0; k < VEC_W / 8; k++) begin : g_byte
        byte_fill_chk: assert property (@(posedge clk) disable iff (rst)
            out_valid |-> (mask[8*k +: 8] == 8'h00 || mask[8*k +: 8] == 8'hFF));
    end
endmodule

bind simd_cmp_unit simd_cmp_unit_chk #(.VEC_W(VEC_W)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .in_valid  (in_valid),
    .out_valid (out_valid),
    .mask      (mask),
    .cond      (cond),
    .cond_we   (cond_we),
    .illegal   (illegal)
);

// File: tb/simd_cmp_unit_bench.sv
module simd_cmp_unit_bench;
    localparam int CLK_PERIOD = 10;
    localparam int VW = 128;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          in_valid = 1'b0;
    logic [31:0]   insn = '0;
    logic [VW-1:0] src_a = '0;
    logic [VW-1:0] src_b = '0;
    logic          out_valid;
    logic [VW-1:0] mask;
    logic [3:0]    cond;
    logic          cond_we;
    logic          illegal;

    int n_checks = 0;
    int n_fail   = 0;
    bit finished = 0;
    logic [VW-1:0] last_mask = '0;

    typedef struct {
        logic [VW-1:0] m;
        logic [3:0]    c;
        logic          we;
        logic          ill;
        string         tag;
    } exp_t;

    exp_t sb_q[$];

    always #(CLK_PERIOD/2) clk = ~clk;

    simd_cmp_unit #(.VEC_W(VW)) u_simd_cmp_unit (
        .clk, .rst, .in_valid, .insn, .src_a, .src_b,
        .out_valid, .mask, .cond, .cond_we, .illegal
    );

    function automatic logic [31:0] mk(input logic [5:0] prim, input logic [9:0] xo,
                                       input logic rc);
        return {prim, 5'd7, 5'd19, 5'd30, rc, xo};
    endfunction

    function automatic logic [31:0] lane_of(input logic [VW-1:0] v, input int w, input int i);
        logic [VW-1:0] s;
        logic [31:0]   lm;
        s  = v >> (VW - (i + 1) * w);
        lm = (w == 32) ? 32'hFFFF_FFFF : ((32'd1 << w) - 32'd1);
        return s[31:0] & lm;
    endfunction

    function automatic exp_t model(input logic [31:0] iw, input logic [VW-1:0] a,
                                   input logic [VW-1:0] b, input string tag);
        exp_t e;
        int   w;
        int   rel;
        bit   ok;
        ok = (iw[31:26] == 6'd4);
        w = 8; rel = 0;
        case (iw[9:0])
            10'd6:   begin w = 8;  rel = 0; end
            10'd70:  begin w = 16; rel = 0; end
            10'd134: begin w = 32; rel = 0; end
            10'd518: begin w = 8;  rel = 1; end
            10'd582: begin w = 16; rel = 1; end
            10'd646: begin w = 32; rel = 1; end
            10'd774: begin w = 8;  rel = 2; end
            10'd838: begin w = 16; rel = 2; end
            10'd902: begin w = 32; rel = 2; end
            default: ok = 0;
        endcase
        e.tag = tag;
        e.m   = '0;
        if (ok) begin
            for (int i = 0; i < VW / w; i++) begin
                logic [31:0] la, lb, sb;
                bit hit;
                la = lane_of(a, w, i);
                lb = lane_of(b, w, i);
                sb = 32'd1 << (w - 1);
                if (rel == 0)      hit = (la == lb);
                else if (rel == 1) hit = (la > lb);
                else               hit = ((la ^ sb) > (lb ^ sb));
                for (int j = 0; j < w; j++) e.m[VW - 1 - i * w - j] = hit;
            end
        end
        e.ill = !ok;
        e.we  = ok && iw[10];
        e.c   = e.we ? {(e.m == {VW{1'b1}}), 1'b0, (e.m == '0), 1'b0} : 4'b0000;
        return e;
    endfunction

    task automatic drive(input logic [31:0] iw, input logic [VW-1:0] a,
                         input logic [VW-1:0] b, input string tag);
        @(negedge clk);
        in_valid = 1'b1;
        insn     = iw;
        src_a    = a;
        src_b    = b;
        sb_q.push_back(model(iw, a, b, tag));
    endtask

    task automatic idle(input int n);
        for (int k = 0; k < n; k++) begin
            @(negedge clk);
            in_valid = 1'b0;
        end
    endtask

    task automatic check(input bit ok, input string what, input string act, input string exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%s expected=%s", what, act, exp);
        end
    endtask

    // Scoreboard monitor
    always @(negedge clk) begin
        if (!rst && out_valid) begin
            if (sb_q.size() == 0) begin
                check(0, "R10 unexpected out_valid", "1", "0");
            end else begin
                exp_t e;
                e = sb_q.pop_front();
                check(mask == e.m && cond == e.c && cond_we == e.we && illegal == e.ill,
                      e.tag,
                      $sformatf("m=%h c=%b we=%b ill=%b", mask, cond, cond_we, illegal),
                      $sformatf("m=%h c=%b we=%b ill=%b", e.m, e.c, e.we, e.ill));
                last_mask = e.m;
            end
        end
    end

    task automatic report;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
        $finish;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            check(0, "watchdog expired", "running", "done");
            report();
        end
    end

    initial begin
        logic [VW-1:0] pa, pb;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R11 reset state
        check(out_valid == 0 && mask == '0 && cond == 0 && cond_we == 0 && illegal == 0,
              "R11 reset outputs",
              $sformatf("v=%b m=%h c=%b we=%b ill=%b", out_valid, mask, cond, cond_we, illegal),
              "all zero");

        pa = 128'h0011_2233_4455_6677_8899_AABB_CCDD_EEFF;
        pb = 128'h0011_2234_4455_6677_8899_ABBB_CCDD_EEF0;
        drive(mk(6'd4, 10'd6, 1'b1), pa, pb, "R2 byte equality mixed");
        drive(mk(6'd4, 10'd6, 1'b1), pa, pa, "R7 byte equality all true");
        drive(mk(6'd4, 10'd6, 1'b1), pa, ~pa, "R7 byte equality all false");
        drive(mk(6'd4, 10'd70, 1'b1), pa, pb, "R3 halfword equality");
        drive(mk(6'd4, 10'd134, 1'b1), pa, pb, "R4 word equality");
        drive(mk(6'd4, 10'd518, 1'b1), {16{8'h80}}, {16{8'h7F}}, "R5 byte gtu all true");
        drive(mk(6'd4, 10'd774, 1'b1), {16{8'h80}}, {16{8'h7F}}, "R6 byte gts all false");
        drive(mk(6'd4, 10'd582, 1'b1), pa, pb, "R5 halfword gtu");
        drive(mk(6'd4, 10'd646, 1'b0),
              128'h8000_0000_0000_0001_7FFF_FFFF_0000_0000,
              128'h7FFF_FFFF_0000_0002_8000_0000_0000_0000, "R5 word gtu");
        drive(mk(6'd4, 10'd838, 1'b1), pa, pb, "R6 halfword gts");
        drive(mk(6'd4, 10'd902, 1'b1),
              128'h8000_0000_0000_0001_7FFF_FFFF_FFFF_FFFF,
              128'h7FFF_FFFF_0000_0002_8000_0000_FFFF_FFFE, "R6 word gts");
        drive(mk(6'd4, 10'd6, 1'b0), pa, pa, "R8 no record bit");
        drive(mk(6'd5, 10'd6, 1'b1), pa, pa, "R9 wrong primary opcode");
        drive(mk(6'd4, 10'd198, 1'b1), pa, pa, "R9 unlisted extended opcode");
        drive(mk(6'd4, 10'd262, 1'b1), pa, pb, "R9 unlisted relation code");
        drive({6'd4, 5'd31, 5'd0, 5'd17, 1'b1, 10'd70}, pa, pb, "R1 register fields ignored");
        drive(mk(6'd4, 10'd70, 1'b1), pa, pb, "R1 reference for field test");
        drive(mk(6'd4, 10'd6, 1'b1), pa, pb, "R10 last before idle");
        idle(1);
        @(negedge clk);
        // R10 mask holds and strobes drop without in_valid
        check(out_valid == 0 && cond_we == 0 && illegal == 0 && cond == 0 && mask == last_mask,
              "R10 idle hold",
              $sformatf("v=%b we=%b ill=%b m=%h", out_valid, cond_we, illegal, mask),
              $sformatf("v=0 we=0 ill=0 m=%h", last_mask));
        idle(3);
        check(sb_q.size() == 0, "R10 all results delivered",
              $sformatf("%0d", sb_q.size()), "0");
        // R11 reset mid-run clears outputs
        drive(mk(6'd4, 10'd6, 1'b1), pa, pa, "R11 pre-reset item");
        @(negedge clk);
        in_valid = 1'b0;
        rst = 1'b1;
        void'(sb_q.pop_front());
        @(negedge clk);
        check(out_valid == 0 && mask == '0 && cond == 0 && cond_we == 0 && illegal == 0,
              "R11 reset clears outputs",
              $sformatf("v=%b m=%h c=%b", out_valid, mask, cond), "all zero");
        rst = 1'b0;
        idle(2);
        finished = 1;
        report();
    end
endmodule